// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block sits between an internal request/acknowledge host port and an external general-purpose parallel bus. It turns each single read or write request into one bus cycle. The bus has a shared data/address pin group, a forwarded bus clock, a frame strobe and separate read and write strobes. One of four width modes decides how the shared pins are split between data and address.

The host holds a request with its address, write data, direction and access size until it sees a one-cycle acknowledge. For reads, the captured data comes back alongside that acknowledge. The mode, the slow-write option and the ready option are sampled with each accepted request. They then stay fixed for the whole access.

When the ready option is on in a mode that has address pins, the top address pin is taken out of the address. It becomes an active-high wait input, and the cycle stretches one bus clock at a time while that input reads low.

Top module: `gpb_master`

## Requirements
- R1: While reset is low at a clock edge, and afterwards until a request is accepted, `bus_frame`, `bus_rd`, `bus_wr`, `bus_clk` and `host_ack` are 0. `bus_dout`, `bus_oe` and `host_rdata` are all zero.
- R2: The mode code (`cfg_mode`) selects the pin split on the 32 shared pins, for both `bus_dout` and `bus_oe`:
  - 0: data on pins 7:0, address on pins 27:8.
  - 1: data on pins 15:0, address on pins 27:16.
  - 2: data on pins 23:0, address on pins 27:24.
  - 3: data on pins 31:0, no address.
  - Pins above the used range are driven 0 with output enable 0.
- R3: The external address is the host byte address shifted right by 1 in mode 1 and not shifted in modes 0 and 2. Only its low bits that fit the mode's address pins are placed on those pins (external bit 0 on the lowest address pin). Higher bits are dropped.
- R4: A write keeps `bus_frame` and `bus_wr` high for one bus clock (two system clocks), or for two bus clocks when `cfg_wr_slow` is 1. `bus_rd` stays 0.
- R5: A read keeps `bus_frame` and `bus_rd` high for two bus clocks, with `bus_wr` 0. The data pins are not enabled. Read data is sampled from `bus_din` at the clock edge that ends the high half of the last bus clock.
- R6: With `cfg_rdy_en` set in modes 0 to 2, pin 27 is driven 0 with output enable 0. `bus_din[27]` is sampled at the end of the last bus clock; while it reads 0, one more bus clock is added. Ready is ignored in every earlier bus clock, and entirely in mode 3 or when `cfg_rdy_en` is 0.
- R7: `host_ack` is high for exactly one system clock, the one right after `bus_frame` falls. In that cycle `host_rdata` holds the sampled read data ANDed with the mode's data width and the size (code 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits). After a write it holds zero.
- R8: During a write, data pins carry `host_wdata` masked to the mode's data width and the access size. All of the mode's data pins are enabled, with unused byte lanes driven 0.
- R9: A request is accepted only when neither an access nor an acknowledge is in progress. The command and configuration inputs are sampled at that acceptance. Changes to them afterwards, including a request held high during the acknowledge cycle, have no effect on the access.
- R10: Within an access each bus clock is two system clocks, with `bus_clk` low in the first and high in the second. `bus_clk` is low when idle. The address and data pins are stable for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Pin split mode code |
| cfg_wr_slow | input | 1 | Add one bus clock to writes |
| cfg_rdy_en | input | 1 | Use top address pin as ready input |
| host_req | input | 1 | Request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size code |
| host_addr | input | HADDR_W | Host byte address |
| host_wdata | input | PIN_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | PIN_W | Read data, valid with acknowledge |
| bus_dout | output | PIN_W | Shared pin output values |
| bus_oe | output | PIN_W | Per-pin output enable |
| bus_din | input | PIN_W | Shared pin input values |
| bus_clk | output | 1 | Forwarded bus clock |
| bus_frame | output | 1 | High for the whole access |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |

## Verification
The bench builds the block with its default values: 32 shared pins and a 32-bit host address. This places the ready pin at 27 and gives all four pin splits, including the case of no address pins.

The wide host address lets addresses with high bits set show the dropping of bits beyond each mode's address width. The bench also uses stalls of zero to three bus clocks, and stalls in mode 3 where ready must be ignored.

// File: rtl/gpb_pkg.sv
// Shared types and constants for the parallel bus master.
// Assumes the four pin-split modes share one pin group whose top
// CTRL_PINS positions are never used for data or address.
package gpb_pkg;

    // Pin split selector, the data width grows by a quarter per code.
    typedef enum logic [1:0] {
        GPB_D8  = 2'd0,
        GPB_D16 = 2'd1,
        GPB_D24 = 2'd2,
        GPB_D32 = 2'd3
    } gpb_mode_e;

    // Access phase state of the sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_ACK  = 2'd2
    } gpb_seq_e;

    // Pins above the address span that carry no data or address in narrow modes.
    localparam int CTRL_PINS = 4;

endpackage

// File: rtl/gpb_pin_map.sv
// Pin map: places latched command data and address on the shared pins.
// Purely combinational. Assumes PIN_W is a multiple of 4 and that the
// address span is PIN_W - CTRL_PINS, so the ready pin is the top of it.
module gpb_pin_map
    import gpb_pkg::*;
#(
    parameter int PIN_W   = 32,
    parameter int HADDR_W = 32
) (
    input  gpb_mode_e          mode,
    input  logic               rdy_en,
    input  logic               we,
    input  logic [1:0]         size,
    input  logic [HADDR_W-1:0] haddr,
    input  logic [PIN_W-1:0]   wdata,
    output logic [PIN_W-1:0]   pin_word,
    output logic [PIN_W-1:0]   pin_oe,
    output logic [PIN_W-1:0]   lane_mask,
    output logic               rdy_live
);

    localparam int LANE    = PIN_W / 4;
    localparam int SPAN    = PIN_W - CTRL_PINS;
    localparam int RDY_PIN = SPAN - 1;

    logic [31:0]        data_w;
    logic [31:0]        addr_w;
    logic [31:0]        size_bits;
    logic [HADDR_W-1:0] ext_addr;

    // Derive data width, address width, size width and shifted address.
    always_comb begin
        data_w = (32'(mode) + 32'd1) * 32'(LANE);
        addr_w = (data_w < 32'(SPAN)) ? (32'(SPAN) - data_w) : 32'd0;
        case (mode)
            GPB_D16: ext_addr = haddr >> 1;
            GPB_D32: ext_addr = haddr >> 2;
            default: ext_addr = haddr;
        endcase
        case (size)
            2'd0:    size_bits = 32'd8;
            2'd1:    size_bits = 32'd16;
            default: size_bits = 32'(PIN_W);
        endcase
        rdy_live = rdy_en && (addr_w != 32'd0);
    end

    for (genvar g = 0; g < PIN_W; g++) begin : g_pin
        logic [HADDR_W-1:0] slid;
        logic               lm;
        logic               pw;
        logic               po;

        // Decide the role of this pin: data lane, address bit, ready or unused.
        always_comb begin
            slid = ext_addr >> (32'(g) - data_w);
            lm   = (32'(g) < data_w) && (32'(g) < size_bits);
            pw   = 1'b0;
            po   = 1'b0;
            if (32'(g) < data_w) begin
                po = we;
                pw = we & lm & wdata[g];
            end else if (32'(g) < data_w + addr_w) begin
                if (!(rdy_live && (g == RDY_PIN))) begin
                    po = 1'b1;
                    pw = slid[0];
                end
            end
        end

        assign lane_mask[g] = lm;
        assign pin_word[g]  = pw;
        assign pin_oe[g]    = po;
    end

endmodule

// File: rtl/gpb_cycle_seq.sv
// Cycle sequencer: runs one bus access of two system clocks per bus clock,
// counts bus clocks up to the base length, stretches on a low ready and
// raises a one-cycle acknowledge. Assumes its command inputs are held
// stable by the caller for the whole access.
module gpb_cycle_seq
    import gpb_pkg::*;
#(
    parameter int MAX_BASE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic we,
    input  logic wr_slow,
    input  logic rdy_live,
    input  logic rdy_in,
    output logic idle,
    output logic busy,
    output logic bclk,
    output logic finish,
    output logic ack
);

    localparam int CNT_W = $clog2(MAX_BASE + 1);

    gpb_seq_e         st;
    logic             phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic             at_last;
    logic             ready_ok;

    // Index of the last base bus clock and completion condition.
    always_comb begin
        last_idx = (we && !wr_slow) ? CNT_W'(0) : CNT_W'(1);
        at_last  = (cnt == last_idx);
        ready_ok = !rdy_live || rdy_in;
        finish   = (st == SEQ_RUN) && phase && at_last && ready_ok;
        idle     = (st == SEQ_IDLE);
        busy     = (st == SEQ_RUN);
        ack      = (st == SEQ_ACK);
        bclk     = (st == SEQ_RUN) && phase;
    end

    // Advance phase, bus clock count and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SEQ_IDLE;
            phase <= 1'b0;
            cnt   <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        st    <= SEQ_RUN;
                        phase <= 1'b0;
                        cnt   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        if (at_last && ready_ok) begin
                            st <= SEQ_ACK;
                        end else if (!at_last) begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    st <= SEQ_IDLE;
                end
            endcase
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R7
    AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (bclk != $past(bclk))); // R10
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase && at_last && !ready_ok) |=> (busy && !bclk)); // R6

endmodule

// File: rtl/gpb_master.sv
// Parallel bus master top: accepts one host request at a time, latches the
// command with its configuration, drives the shared pins through the pin
// map and the strobes from the sequencer, and returns read data with the
// acknowledge. Assumes the host holds its request until acknowledge.
module gpb_master
    import gpb_pkg::*;
#(
    parameter int HADDR_W = 32,
    parameter int PIN_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_wr_slow,
    input  logic               cfg_rdy_en,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [1:0]         host_size,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [PIN_W-1:0]   host_wdata,
    output logic               host_ack,
    output logic [PIN_W-1:0]   host_rdata,
    output logic [PIN_W-1:0]   bus_dout,
    output logic [PIN_W-1:0]   bus_oe,
    input  logic [PIN_W-1:0]   bus_din,
    output logic               bus_clk,
    output logic               bus_frame,
    output logic               bus_rd,
    output logic               bus_wr
);

    localparam int RDY_PIN = PIN_W - CTRL_PINS - 1;

    gpb_mode_e          cmd_mode;
    logic               cmd_we;
    logic               cmd_wr_slow;
    logic               cmd_rdy_en;
    logic [1:0]         cmd_size;
    logic [HADDR_W-1:0] cmd_addr;
    logic [PIN_W-1:0]   cmd_wdata;
    logic [PIN_W-1:0]   rdata_q;

    logic               seq_idle;
    logic               seq_busy;
    logic               seq_bclk;
    logic               seq_finish;
    logic               seq_ack;
    logic               accept;

    logic [PIN_W-1:0]   pin_word;
    logic [PIN_W-1:0]   pin_oe;
    logic [PIN_W-1:0]   lane_mask;
    logic               rdy_live;

    assign accept = host_req && seq_idle;

    // Latch command and configuration when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_mode    <= GPB_D8;
            cmd_we      <= 1'b0;
            cmd_wr_slow <= 1'b0;
            cmd_rdy_en  <= 1'b0;
            cmd_size    <= 2'd0;
            cmd_addr    <= '0;
            cmd_wdata   <= '0;
        end else if (accept) begin
            cmd_mode    <= gpb_mode_e'(cfg_mode);
            cmd_we      <= host_we;
            cmd_wr_slow <= cfg_wr_slow;
            cmd_rdy_en  <= cfg_rdy_en;
            cmd_size    <= host_size;
            cmd_addr    <= host_addr;
            cmd_wdata   <= host_wdata;
        end
    end

    // Capture masked read data, or zero for a write, at the final bus edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (seq_finish) begin
            rdata_q <= cmd_we ? '0 : (bus_din & lane_mask);
        end
    end

    gpb_pin_map #(
        .PIN_W   (PIN_W),
        .HADDR_W (HADDR_W)
    ) u_map (
        .mode      (cmd_mode),
        .rdy_en    (cmd_rdy_en),
        .we        (cmd_we),
        .size      (cmd_size),
        .haddr     (cmd_addr),
        .wdata     (cmd_wdata),
        .pin_word  (pin_word),
        .pin_oe    (pin_oe),
        .lane_mask (lane_mask),
        .rdy_live  (rdy_live)
    );

    gpb_cycle_seq #(
        .MAX_BASE (2)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .we       (cmd_we),
        .wr_slow  (cmd_wr_slow),
        .rdy_live (rdy_live),
        .rdy_in   (bus_din[RDY_PIN]),
        .idle     (seq_idle),
        .busy     (seq_busy),
        .bclk     (seq_bclk),
        .finish   (seq_finish),
        .ack      (seq_ack)
    );

    // Gate pins and strobes with the access window.
    always_comb begin
        bus_dout   = seq_busy ? pin_word : '0;
        bus_oe     = seq_busy ? pin_oe   : '0;
        bus_frame  = seq_busy;
        bus_clk    = seq_bclk;
        bus_rd     = seq_busy && !cmd_we;
        bus_wr     = seq_busy && cmd_we;
        host_ack   = seq_ack;
        host_rdata = rdata_q;
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_frame |-> (bus_oe == '0 && !bus_rd && !bus_wr && !bus_clk)); // R1
    AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_frame && $past(bus_frame)) |-> ($stable(bus_dout) && $stable(bus_oe))); // R10
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_frame |-> ((bus_dout & ~bus_oe) == '0)); // R8
    AST_ACK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> ($past(bus_frame) && !bus_frame)); // R7
    AST_READY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_frame && rdy_live) |-> !bus_oe[RDY_PIN]); // R6

endmodule

// File: tb/tb_gpb_master.sv
// Bench: a queue of per-cycle expected records built behaviourally from the
// requirements, compared at every falling clock edge.
module tb_gpb_master;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_wr_slow = 1'b0;
    logic        cfg_rdy_en = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic [31:0] bus_dout;
    logic [31:0] bus_oe;
    logic [31:0] bus_din = '0;
    logic        bus_clk;
    logic        bus_frame;
    logic        bus_rd;
    logic        bus_wr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          req;
        bit          we;
        logic [1:0]  mode;
        bit          wr2;
        bit          rdy;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] din;
        bit          f, c, rd, wr, ack, chk_rd;
        logic [31:0] dout, oe, rdata;
        int          tag;
        int          strobe_tag;
    } rec_t;

    rec_t q[$];

    gpb_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wr_slow(cfg_wr_slow),
        .cfg_rdy_en(cfg_rdy_en), .host_req(host_req), .host_we(host_we),
        .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .bus_din(bus_din), .bus_clk(bus_clk),
        .bus_frame(bus_frame), .bus_rd(bus_rd), .bus_wr(bus_wr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, int req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic rec_t idle_rec();
        rec_t r;
        r = '{default: 0};
        r.tag = 1;
        r.strobe_tag = 1;
        return r;
    endfunction

    // Build the expected windows of one access: accept, access clocks, acknowledge.
    task automatic push_txn(bit we, logic [1:0] mode, bit wr2, bit rdy, logic [1:0] size,
                            logic [31:0] addr, logic [31:0] wdata, logic [31:0] rval,
                            int k, int tag, bit hold_ack);
        rec_t r;
        int dw, aw, sb, nclk, sh;
        bit live;
        logic [31:0] ext, ed, eoe, dmask, fin;
        dw = (int'(mode) + 1) * 8;
        aw = (dw < 28) ? 28 - dw : 0;       // R2 split
        sb = (size == 2'd0) ? 8 : (size == 2'd1) ? 16 : 32;
        sh = (mode == 2'd1) ? 1 : 0;        // R3 half-word shift
        ext = addr >> sh;
        live = rdy && (aw > 0);              // R6 ready only with address pins
        nclk = (we ? (wr2 ? 2 : 1) : 2) + (live ? k : 0);
        ed = '0; eoe = '0; dmask = '0;
        for (int p = 0; p < 32; p++) begin
            if (p < dw) begin
                dmask[p] = 1'b1;
                if (we) begin
                    eoe[p] = 1'b1;
                    if (p < sb) ed[p] = wdata[p];   // R8 lane masking
                end
            end else if (p < dw + aw) begin
                if (!(live && p == 27)) begin
                    eoe[p] = 1'b1;
                    ed[p] = ext[p - dw];
                end
            end
        end
        fin = rval & dmask;
        if (live) fin[27] = 1'b1;
        r = idle_rec();
        r.req = 1'b1; r.we = we; r.mode = mode; r.wr2 = wr2; r.rdy = rdy;
        r.size = size; r.addr = addr; r.wdata = wdata;
        r.tag = tag;
        q.push_back(r);
        for (int j = 1; j <= nclk; j++) begin
            for (int h = 0; h < 2; h++) begin
                r = idle_rec();
                // R9: command inputs change while busy and must be ignored
                r.req = 1'b1; r.we = !we; r.mode = ~mode; r.wr2 = !wr2; r.rdy = !rdy;
                r.size = ~size; r.addr = ~addr; r.wdata = ~wdata;
                r.f = 1'b1; r.c = (h == 1); r.rd = !we; r.wr = we;
                r.dout = ed; r.oe = eoe; r.tag = tag;
                r.strobe_tag = we ? 4 : 5;
                r.din = ~rval;
                if (live) r.din[27] = 1'b0;
                if (h == 1 && j == nclk) r.din = fin;
                q.push_back(r);
            end
        end
        r = idle_rec();
        r.ack = 1'b1; r.chk_rd = 1'b1;
        r.rdata = we ? 32'h0 : (rval & dmask & ((sb == 32) ? 32'hFFFF_FFFF : ((32'h1 << sb) - 1)));
        r.tag = 7; r.strobe_tag = 7;
        if (hold_ack) begin
            r.req = 1'b1; r.we = 1'b1; r.addr = 32'h0000_0FFF; r.wdata = 32'hFFFF_FFFF;
        end
        q.push_back(r);
    endtask

    task automatic push_idle(int n);
        for (int i = 0; i < n; i++) q.push_back(idle_rec());
    endtask

    task automatic compare(rec_t r);
        chk(bus_frame == r.f, r.strobe_tag, "frame", 32'(bus_frame), 32'(r.f));
        chk(bus_rd == r.rd && bus_wr == r.wr, r.strobe_tag, "rd/wr",
            {30'd0, bus_rd, bus_wr}, {30'd0, r.rd, r.wr});
        chk(bus_clk == r.c, 10, "bus clock", 32'(bus_clk), 32'(r.c));   // R10
        chk(bus_dout == r.dout, r.tag, "pin values", bus_dout, r.dout);
        chk(bus_oe == r.oe, r.tag, "pin enables", bus_oe, r.oe);
        chk(host_ack == r.ack, 7, "ack", 32'(host_ack), 32'(r.ack));     // R7
        if (r.chk_rd) chk(host_rdata == r.rdata, r.tag, "read data", host_rdata, r.rdata);
    endtask

    task automatic drive(rec_t r);
        host_req = r.req; host_we = r.we; cfg_mode = r.mode; cfg_wr_slow = r.wr2;
        cfg_rdy_en = r.rdy; host_size = r.size; host_addr = r.addr;
        host_wdata = r.wdata; bus_din = r.din;
    endtask

    initial begin
        rec_t r;
        // R1: reset state with request inputs active
        host_req = 1'b1; host_we = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r = idle_rec();
        r.chk_rd = 1'b1;
        compare(r);
        host_req = 1'b0; host_we = 1'b0;
        rst_n = 1'b1;

        // R2/R3: mode 0 write, address bits above 20 dropped
        push_txn(1, 2'd0, 0, 0, 2'd0, 32'hFFF1_2345, 32'hA5A5_A5C3, 32'h0, 0, 3, 0);
        push_idle(1);
        // R5: mode 0 read, byte size
        push_txn(0, 2'd0, 0, 0, 2'd0, 32'h000A_BCDE, 32'h0, 32'h0012_3456, 0, 5, 0);
        // R3: mode 1 half-word address shift
        push_txn(1, 2'd1, 0, 0, 2'd1, 32'h0000_2468, 32'hDEAD_BEEF, 32'h0, 0, 3, 0);
        // R7: mode 1 read masked to 16 data pins
        push_txn(0, 2'd1, 0, 0, 2'd2, 32'h0000_0010, 32'h0, 32'hCAFE_1234, 0, 7, 0);
        // R4: mode 2 slow write
        push_txn(1, 2'd2, 1, 0, 2'd2, 32'h0000_0037, 32'h1122_3344, 32'h0, 0, 4, 0);
        push_idle(2);
        // R7: mode 2 read, half-word size
        push_txn(0, 2'd2, 0, 0, 2'd1, 32'h0000_0005, 32'h0, 32'h00FF_EEDD, 0, 7, 0);
        // R2: mode 3 write, no address pins
        push_txn(1, 2'd3, 0, 0, 2'd2, 32'hFFFF_FFFF, 32'h89AB_CDEF, 32'h0, 0, 2, 0);
        // R7: mode 3 read, byte size
        push_txn(0, 2'd3, 0, 0, 2'd0, 32'h0000_0000, 32'h0, 32'h7F00_55AA, 0, 7, 0);
        // R8: mode 3 half-word write, upper lanes zero but enabled
        push_txn(1, 2'd3, 0, 0, 2'd1, 32'h0000_0000, 32'h1234_5678, 32'h0, 0, 8, 0);
        // R6: mode 0 read stretched by two bus clocks, pin 27 released
        push_txn(0, 2'd0, 0, 1, 2'd2, 32'h000F_FFFF, 32'h0, 32'h0000_00C5, 2, 6, 0);
        // R6: mode 1 write with ready already high
        push_txn(1, 2'd1, 0, 1, 2'd1, 32'h0000_1FFE, 32'h0000_BEEF, 32'h0, 0, 6, 0);
        // R6: mode 2 slow write stretched by one bus clock
        push_txn(1, 2'd2, 1, 1, 2'd2, 32'h0000_000F, 32'h00AB_CDEF, 32'h0, 1, 6, 0);
        // R6: mode 3 ignores ready enable
        push_txn(0, 2'd3, 0, 1, 2'd2, 32'h0000_0000, 32'h0, 32'h1357_9BDF, 3, 6, 0);
        // R6: ready disabled, pin 27 toggling ignored
        push_txn(0, 2'd1, 0, 0, 2'd2, 32'h0000_0ABC, 32'h0, 32'h0000_F00D, 0, 6, 0);
        // R9: request held through acknowledge is not taken
        push_txn(1, 2'd0, 0, 0, 2'd0, 32'h0000_0001, 32'h0000_0055, 32'h0, 0, 9, 1);
        push_idle(2);
        // R5: mode 2 read with ready high at once
        push_txn(0, 2'd2, 0, 1, 2'd2, 32'h0000_0003, 32'h0, 32'h0012_3456, 0, 5, 0);
        push_idle(2);

        while (q.size() > 0) begin
            @(negedge clk);
            r = q.pop_front();
            compare(r);
            drive(r);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule